// File: doc/BRIEF.md
# Real-Time Clock Update Sequencer with Alarm and Interrupt Flags

This block paces the once-per-second advance of a binary hours/minutes/seconds counter from a 32.768 kHz tick strobe. A fixed number of ticks before each second boundary it raises an update-in-progress status bit. At the boundary the time advances by one second. After a further fixed window the status bit drops, and the block compares the new time against two alarm settings, a main alarm and an extended alarm.

When the window closes it sets an update-ended flag, plus an alarm flag for each alarm that matches. A periodic-pulse input sets a periodic flag. Each flag is gated by its own enable bit into a master interrupt flag, which drives the active-low interrupt pin. The extended alarm has its own status register and its own active-low pin. Software uses a small byte-wide register bus. While the status bit is high, reads of the time return the value from before the update, so software never sees a half-advanced time. Reading a flag register returns its flags and clears them.

Top module: `rtc_upd_ctrl`

## Requirements
- R1: After reset, the time reads 00:00:00, every flag is 0, `uip` is 0, and both `irq_n` and `xirq_n` are 1.
- R2: `uip` rises when the tick phase reaches TICKS_PER_SEC-PRE_TICKS ticks since reset, modulo TICKS_PER_SEC. That is PRE_TICKS ticks before the second boundary. `uip` falls WIN_TICKS ticks after the boundary. The time advances at the boundary.
- R3: Each update adds one second in binary. Seconds and minutes run 0..59 and hours 0..23, with the carry passing from seconds to minutes to hours. Addresses are 0 = seconds, 1 = minutes, 2 = hours.
- R4: While `uip` is high, reads at addresses 0..2 return the time as it stood when `uip` rose.
- R5: Every time `uip` falls, the update-ended flag (bit 4 of the flag register, address 11) is set.
- R6: If the new time equals the main alarm when `uip` falls, the alarm flag (bit 5 of address 11) is set. The main alarm is written at addresses 3/4/5 (seconds/minutes/hours). The flag is set whether or not its enable is on.
- R7: The master flag (bit 7 of address 11) is the OR of update-ended AND enable bit 4, alarm AND enable bit 5, and periodic AND enable bit 6. The enables are in the control register at address 10. `irq_n` is the inverse of the master flag and stays low until the flags are cleared.
- R8: A one-cycle high on `pi_pulse` sets the periodic flag (bit 6 of address 11).
- R9: A read of address 11 returns the flags and clears bits 4..6 at that clock edge. A flag set by an event in the same cycle as the read survives the clear.
- R10: A match of the new time against the extended alarm (addresses 6/7/8) sets bit 5 of address 12 and the `xaf` output. `xirq_n` is low while this flag and enable bit 0 of address 10 are both set. Only a read of address 12 clears this flag.
- R11: Address 10 reads back the value written to it. Address 9 reads `uip` in bit 7 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| pi_pulse | input | 1 | One-cycle periodic pulse |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears flags at addresses 11 and 12) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| uip | output | 1 | Update-in-progress status |
| stat_c | output | 8 | Flag register: 7 master, 6 periodic, 5 alarm, 4 update-ended |
| xaf | output | 1 | Extended alarm flag |
| irq_n | output | 1 | Active-low main interrupt |
| xirq_n | output | 1 | Active-low extended alarm interrupt |

## Verification
Two functions can land on the same clock edge: the end of the update window setting the update-ended flag, and a software read of the flag register clearing it. To force this, the bench holds a read of address 11 on every cycle through a whole update window. In the first cycle after `uip` falls, the returned value must show the update-ended flag, which proves the set beat the clear. One cycle later the value must read zero. A sweep across every hour, minute and second carry case checks the counter against times that the bench computes from a total-seconds count.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;

  // register addresses
  localparam logic [3:0] AD_SEC  = 4'd0;
  localparam logic [3:0] AD_MIN  = 4'd1;
  localparam logic [3:0] AD_HR   = 4'd2;
  localparam logic [3:0] AD_ALM0 = 4'd3;
  localparam logic [3:0] AD_STA  = 4'd9;
  localparam logic [3:0] AD_CTL  = 4'd10;
  localparam logic [3:0] AD_FLG  = 4'd11;
  localparam logic [3:0] AD_XFL  = 4'd12;

  // control bit positions
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;
  localparam int B_XAIE = 0;

  // one-second advance with ordered carries
  function automatic hms_t hms_next(input hms_t t);
    hms_t n;
    n = t;
    if (t.sc >= 6'd59) begin
      n.sc = '0;
      if (t.mn >= 6'd59) begin
        n.mn = '0;
        n.hr = (t.hr >= 5'd23) ? 5'd0 : t.hr + 5'd1;
      end else begin
        n.mn = t.mn + 6'd1;
      end
    end else begin
      n.sc = t.sc + 6'd1;
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int TICKS = 32768,
  parameter int PRE   = 8,
  parameter int WIN   = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic uip,
  output logic evt_rise,
  output logic evt_xfer,
  output logic evt_end
);
  localparam int PH_W = $clog2(TICKS);
  localparam int WC_W = $clog2(WIN + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(TICKS - PRE - 1);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN - 1);

  logic [PH_W-1:0] ph_q;
  logic [WC_W-1:0] wc_q;
  logic            in_win_q;

  assign evt_rise = tick && (ph_q == PH_RISE);
  assign evt_xfer = tick && (ph_q == PH_LAST);
  assign evt_end  = tick && in_win_q && (wc_q == WC_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= '0;
      wc_q     <= '0;
      in_win_q <= 1'b0;
      uip      <= 1'b0;
    end else begin
      if (tick) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      if (evt_rise) uip <= 1'b1;
      else if (evt_end) uip <= 1'b0;
      if (evt_xfer) begin
        in_win_q <= 1'b1;
        wc_q     <= '0;
      end else if (evt_end) begin
        in_win_q <= 1'b0;
      end else if (in_win_q && tick) begin
        wc_q <= wc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_rise,
  input  logic       evt_xfer,
  input  logic       uip,
  input  logic       wr_sc,
  input  logic       wr_mn,
  input  logic       wr_hr,
  input  logic [5:0] wdata,
  output hms_t       live,
  output hms_t       view
);
  hms_t hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= '0;
      hold_q <= '0;
    end else begin
      if (evt_xfer) live <= hms_next(live);
      if (wr_sc) live.sc <= wdata;
      if (wr_mn) live.mn <= wdata;
      if (wr_hr) live.hr <= wdata[4:0];
      if (evt_rise) hold_q <= live;
    end
  end

  assign view = uip ? hold_q : live;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_upd_pkg::*;
#(
  parameter int N_ALM = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_end,
  input  logic             pi_pulse,
  input  hms_t             now,
  input  hms_t [N_ALM-1:0] alm,
  input  logic             ie_uf,
  input  logic             ie_af,
  input  logic             ie_pf,
  input  logic             ie_xa,
  input  logic             rd_c,
  input  logic             rd_x,
  output logic [7:0]       stat_c,
  output logic             xaf,
  output logic             irqf,
  output logic             xirqf
);
  logic [N_ALM-1:0] hit;
  logic uf_q, af_q, pf_q;

  for (genvar g = 0; g < N_ALM; g++) begin : g_cmp
    assign hit[g] = evt_end && (now == alm[g]);
  end

  // set beats clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf_q <= 1'b0;
      af_q <= 1'b0;
      pf_q <= 1'b0;
      xaf  <= 1'b0;
    end else begin
      uf_q <= evt_end  ? 1'b1 : (rd_c ? 1'b0 : uf_q);
      af_q <= hit[0]   ? 1'b1 : (rd_c ? 1'b0 : af_q);
      pf_q <= pi_pulse ? 1'b1 : (rd_c ? 1'b0 : pf_q);
      xaf  <= hit[N_ALM-1] ? 1'b1 : (rd_x ? 1'b0 : xaf);
    end
  end

  assign irqf   = (uf_q & ie_uf) | (af_q & ie_af) | (pf_q & ie_pf);
  assign xirqf  = xaf & ie_xa;
  assign stat_c = {irqf, pf_q, af_q, uf_q, 4'b0000};
endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int PRE_TICKS     = 8,
  parameter int WIN_TICKS     = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       pi_pulse,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       uip,
  output logic [7:0] stat_c,
  output logic       xaf,
  output logic       irq_n,
  output logic       xirq_n
);
  localparam int N_ALM = 2;

  logic evt_rise, evt_xfer, evt_end;
  logic irqf, xirqf;
  logic rd_c, rd_x, any_wr;
  logic wr_sc, wr_mn, wr_hr;
  logic [7:0] ctl_q;
  hms_t t_live, t_view;
  hms_t [N_ALM-1:0] alm_vec;
  logic [5:0] live_sc, view_sc;

  rtc_upd_seq #(
    .TICKS(TICKS_PER_SEC), .PRE(PRE_TICKS), .WIN(WIN_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .uip(uip),
    .evt_rise(evt_rise), .evt_xfer(evt_xfer), .evt_end(evt_end)
  );

  assign any_wr = bus_wr;
  assign wr_sc  = bus_wr && (bus_addr == AD_SEC);
  assign wr_mn  = bus_wr && (bus_addr == AD_MIN);
  assign wr_hr  = bus_wr && (bus_addr == AD_HR);
  assign rd_c   = bus_rd && (bus_addr == AD_FLG);
  assign rd_x   = bus_rd && (bus_addr == AD_XFL);

  rtc_time_cnt u_time (
    .clk(clk), .rst_n(rst_n), .evt_rise(evt_rise), .evt_xfer(evt_xfer),
    .uip(uip), .wr_sc(wr_sc), .wr_mn(wr_mn), .wr_hr(wr_hr),
    .wdata(bus_wdata[5:0]), .live(t_live), .view(t_view)
  );

  for (genvar g = 0; g < N_ALM; g++) begin : g_alm
    localparam logic [3:0] BASE = AD_ALM0 + 4'(3 * g);
    hms_t a_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= '0;
      end else if (bus_wr) begin
        if (bus_addr == BASE)        a_q.sc <= bus_wdata[5:0];
        if (bus_addr == BASE + 4'd1) a_q.mn <= bus_wdata[5:0];
        if (bus_addr == BASE + 4'd2) a_q.hr <= bus_wdata[4:0];
      end
    end
    assign alm_vec[g] = a_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else if (bus_wr && (bus_addr == AD_CTL)) ctl_q <= bus_wdata;
  end

  rtc_irq_flags #(.N_ALM(N_ALM)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_end(evt_end), .pi_pulse(pi_pulse),
    .now(t_live), .alm(alm_vec),
    .ie_uf(ctl_q[B_UIE]), .ie_af(ctl_q[B_AIE]), .ie_pf(ctl_q[B_PIE]),
    .ie_xa(ctl_q[B_XAIE]), .rd_c(rd_c), .rd_x(rd_x),
    .stat_c(stat_c), .xaf(xaf), .irqf(irqf), .xirqf(xirqf)
  );

  assign irq_n   = ~irqf;
  assign xirq_n  = ~xirqf;
  assign live_sc = t_live.sc;
  assign view_sc = t_view.sc;

  always_comb begin
    case (bus_addr)
      AD_SEC:  bus_rdata = {2'b00, t_view.sc};
      AD_MIN:  bus_rdata = {2'b00, t_view.mn};
      AD_HR:   bus_rdata = {3'b000, t_view.hr};
      AD_STA:  bus_rdata = {uip, 7'b0};
      AD_CTL:  bus_rdata = ctl_q;
      AD_FLG:  bus_rdata = stat_c;
      AD_XFL:  bus_rdata = {2'b00, xaf, 5'b0};
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

module rtc_upd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uip,
  input logic [2:0] flg,
  input logic       irq_n,
  input logic       xirq_n,
  input logic       xaf,
  input logic       rd_c,
  input logic       evt_end,
  input logic       evt_xfer,
  input logic       pi_pulse,
  input logic       any_wr,
  input logic [5:0] live_sc,
  input logic [5:0] view_sc
);
  // R2
  xfer_in_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_xfer |-> uip);
  // R3
  live_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_xfer && !any_wr) |=> (live_sc != $past(live_sc)));
  // R4
  view_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uip && $past(uip)) |-> $stable(view_sc));
  // R5
  uf_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> flg[0]);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_c && !any_wr) |=> !irq_n);
  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !evt_end && !pi_pulse) |=> (flg == 3'b000));
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && evt_end) |=> flg[0]);
  // R10
  xirq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xirq_n |-> xaf);
endmodule

bind rtc_upd_ctrl rtc_upd_chk chk_i (
  .clk(clk), .rst_n(rst_n), .uip(uip), .flg(stat_c[6:4]), .irq_n(irq_n),
  .xirq_n(xirq_n), .xaf(xaf), .rd_c(rd_c), .evt_end(evt_end),
  .evt_xfer(evt_xfer), .pi_pulse(pi_pulse), .any_wr(any_wr),
  .live_sc(live_sc), .view_sc(view_sc)
);

// File: tb/rtc_upd_ctrl_tb.sv
module rtc_upd_ctrl_tb_top;
  localparam int T   = 200;
  localparam int PRE = 8;
  localparam int WIN = 65;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pi = 1'b0;
  logic [3:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdat, stc;
  logic uip, xaf, irq_n, xirq_n;

  int n_chk = 0, n_fail = 0, tick_cnt = 0, cyc = 0;
  int alm0_t = 0, alm1_t = 0;

  rtc_upd_ctrl #(.TICKS_PER_SEC(T), .PRE_TICKS(PRE), .WIN_TICKS(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .pi_pulse(pi),
    .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wd),
    .bus_rdata(rdat), .uip(uip), .stat_c(stc), .xaf(xaf),
    .irq_n(irq_n), .xirq_n(xirq_n)
  );

  always #10 clk = ~clk;
  always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;
  always @(posedge clk) if (rst_n && tick) tick_cnt <= tick_cnt + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #2 v = rdat;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_uip(input logic lvl);
    do @(negedge clk); while (uip !== lvl);
  endtask

  function automatic int secs(input int h, input int m, input int s);
    return h * 3600 + m * 60 + s;
  endfunction

  function automatic int packed_of(input int t);
    return (t / 3600) * 10000 + ((t / 60) % 60) * 100 + (t % 60);
  endfunction

  task automatic set_time(input int h, input int m, input int s);
    wr_reg(4'd0, 8'(s));
    wr_reg(4'd1, 8'(m));
    wr_reg(4'd2, 8'(h));
  endtask

  task automatic set_alm(input int idx, input int h, input int m, input int s);
    wr_reg(4'(3 + 3 * idx), 8'(s));
    wr_reg(4'(4 + 3 * idx), 8'(m));
    wr_reg(4'(5 + 3 * idx), 8'(h));
    if (idx == 0) alm0_t = secs(h, m, s); else alm1_t = secs(h, m, s);
  endtask

  task automatic run_sec(input int h, input int m, input int s);
    set_time(h, m, s);
    wait_uip(1'b1);
    wait_uip(1'b0);
  endtask

  // one full update with all checks; enables assumed 0
  task automatic do_second(input int h, input int m, input int s);
    logic [7:0] v, vh, vm, vs;
    int nt;
    nt = (secs(h, m, s) + 1) % 86400;
    set_time(h, m, s);
    wait_uip(1'b1);
    rd_reg(4'd0, v);
    chk("R4 seconds frozen during update", int'(v), s);
    wait_uip(1'b0);
    rd_reg(4'd0, vs);
    rd_reg(4'd1, vm);
    rd_reg(4'd2, vh);
    chk("R3 advanced time", int'(vh) * 10000 + int'(vm) * 100 + int'(vs), packed_of(nt));
    rd_reg(4'd11, v);
    chk("R5/R6 flags after update", int'(v), 32'h10 | ((nt == alm0_t) ? 32'h20 : 0));
    rd_reg(4'd12, v);
    chk("R10 extended flag", int'(v), (nt == alm1_t) ? 32'h20 : 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 uip", int'(uip), 0);
    chk("R1 stat", int'(stc), 0);
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 xirq_n", int'(xirq_n), 1);
    rd_reg(4'd0, v); chk("R1 seconds", int'(v), 0);
    rd_reg(4'd1, v); chk("R1 minutes", int'(v), 0);
    rd_reg(4'd2, v); chk("R1 hours", int'(v), 0);

    // R2 window placement, R11 status bit
    wait_uip(1'b1);
    chk("R2 uip rise tick", tick_cnt, T - PRE);
    rd_reg(4'd9, v); chk("R11 status during update", int'(v), 32'h80);
    wait_uip(1'b0);
    chk("R2 uip fall tick", tick_cnt, T + WIN);
    chk("R5 update flag at fall", int'(stc), 32'h10);
    rd_reg(4'd9, v); chk("R11 status idle", int'(v), 0);
    rd_reg(4'd0, v); chk("R3 first second", int'(v), 1);
    rd_reg(4'd11, v); chk("R9 read returns flags", int'(v), 32'h10);
    chk("R9 flags cleared", int'(stc), 0);
    wr_reg(4'd10, 8'h71);
    rd_reg(4'd10, v); chk("R11 control readback", int'(v), 32'h71);
    wr_reg(4'd10, 8'h00);

    // carry sweeps
    for (int h = 0; h < 24; h++) do_second(h, 59, 59);
    for (int s = 0; s < 60; s++) do_second(5, 30, s);
    for (int m = 0; m < 60; m++) do_second(12, m, 59);

    // main alarm enabled
    set_alm(0, 1, 2, 4);
    set_alm(1, 10, 10, 10);
    wr_reg(4'd10, 8'h20);
    run_sec(1, 2, 3);
    chk("R7 irq on enabled alarm", int'(irq_n), 0);
    rd_reg(4'd11, v); chk("R6 alarm with master", int'(v), 32'hB0);
    chk("R9 irq released by read", int'(irq_n), 1);
    rd_reg(4'd11, v); chk("R9 flags empty after read", int'(v), 0);
    chk("R10 xirq idle", int'(xirq_n), 1);
    rd_reg(4'd12, v); chk("R10 no extended match", int'(v), 0);

    // alarm matched but disabled
    wr_reg(4'd10, 8'h00);
    run_sec(1, 2, 3);
    chk("R7 disabled alarm no irq", int'(irq_n), 1);
    rd_reg(4'd11, v); chk("R6 alarm flag without enable", int'(v), 32'h30);

    // update-ended interrupt
    wr_reg(4'd10, 8'h10);
    run_sec(5, 5, 5);
    chk("R7 update irq", int'(irq_n), 0);
    rd_reg(4'd11, v); chk("R7 update master flag", int'(v), 32'h90);

    // extended alarm
    wr_reg(4'd10, 8'h01);
    set_alm(1, 5, 5, 6);
    run_sec(5, 5, 5);
    chk("R10 xirq asserted", int'(xirq_n), 0);
    rd_reg(4'd11, v); chk("R10 main flags separate", int'(v), 32'h10);
    chk("R10 xirq survives main read", int'(xirq_n), 0);
    rd_reg(4'd12, v); chk("R10 extended flag read", int'(v), 32'h20);
    chk("R10 xirq released", int'(xirq_n), 1);
    chk("R10 xaf cleared", int'(xaf), 0);

    // periodic flag
    wr_reg(4'd10, 8'h40);
    @(negedge clk); pi = 1'b1;
    @(negedge clk); pi = 1'b0;
    chk("R8 periodic flag enabled", int'(stc), 32'hC0);
    chk("R7 periodic irq", int'(irq_n), 0);
    rd_reg(4'd11, v); chk("R9 periodic read", int'(v), 32'hC0);
    wr_reg(4'd10, 8'h00);
    @(negedge clk); pi = 1'b1;
    @(negedge clk); pi = 1'b0;
    chk("R8 periodic flag disabled", int'(stc), 32'h40);
    chk("R7 periodic masked", int'(irq_n), 1);
    rd_reg(4'd11, v);

    // R9 read coinciding with end of update
    set_time(7, 7, 7);
    wait_uip(1'b1);
    @(negedge clk);
    addr = 4'd11; rd = 1'b1;
    do begin
      @(negedge clk);
      #2;
    end while (uip);
    chk("R9 set wins over same-cycle read", int'(rdat), 32'h10);
    @(negedge clk);
    #2;
    chk("R9 cleared one cycle later", int'(rdat), 0);
    rd = 1'b0;
    @(negedge clk);
    chk("R9 stat clear", int'(stc), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule